// File: doc/BRIEF.md
# Block-Wise Survivor-Memory Traceback Unit

This unit is the back end of a Viterbi decoder. Every accepted sample brings one decision vector from the add-compare-select array, with one survivor bit per trellis state. The vector is stored as one row of a RAM and is never shifted through a register chain. The RAM is split into four banks of M rows. Bank roles rotate every M accepted samples. One bank takes new rows. One bank is traced back from its newest row only to find the state at the end of the block before it. One bank waits its turn. The oldest bank is decoded backwards from the state that was just found. The decoded bits come out newest first, so a two-half reversal buffer puts them back in time order. One bit leaves per accepted sample.

The unit runs in continuous mode only. Every internal step is gated by `in_valid`. A cycle without valid input freezes the pipeline, and no output is produced in that cycle. The latency is fixed at 4·M accepted samples. The depth M should be about ten times the constraint length. With that depth, a start state taken on block boundaries reaches error rates close to those of full per-bit traceback. The RAM holds 4·M rows of 2^(K-1) bits.

Two control states select the output behaviour. PRIME lasts for the first four blocks after reset and produces no output. STREAM follows and lasts until reset. The only transition is PRIME→STREAM, taken on the last accepted sample of the fourth block.

Top module: `vtb_block_traceback`

## Requirements
- R1: After reset, and for the first 4·M accepted samples, `out_valid` stays 0.
- R2: Once 4·M samples have been accepted, `out_valid` equals `in_valid` in every cycle.
- R3: The bit released together with accepted sample n (n ≥ 4·M) is the decoded bit of sample n−4·M. Bits leave in time order, one per accepted sample.
- R4: State index encoding: bit 0 holds the newest input bit and bit K−2 holds the oldest. One backward step from state s with stored decision d gives {d, s[K−2:1]}. The decoded bit at that step is s[0].
- R5: When `use_min` is 0 on the last sample of a block, the start-state traceback through that block begins at state 0.
- R6: When `use_min` is 1 on the last sample of a block, the start-state traceback through that block begins at `start_state` as sampled on that same last sample.
- R7: A block is decoded from the state reached by tracing back through the following block from its newest row down to its oldest row.
- R8: A cycle with `in_valid` low gives `out_valid` 0. The pipeline does not advance, and `out_bit` is held unchanged.
- R9: If the stored decisions follow one encoder path, and `start_state` is that path's state on the last sample of each block, the output reproduces the encoder's input bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of control, traceback states and reversal buffer |
| in_valid | input | 1 | Accepts `dec_vec` and advances the pipeline by one step |
| dec_vec | input | 2^(K-1) | Survivor decision bit per trellis state |
| use_min | input | 1 | 1: start traceback at `start_state`; 0: start at state 0 |
| start_state | input | K-1 | Minimum-metric state index from the metric unit |
| out_valid | output | 1 | Decoded bit present on `out_bit` |
| out_bit | output | 1 | Decoded bit, in time order |

## Verification
The assertions rely on reset being applied before the first valid sample. They also rely on `in_valid`, `use_min` and `start_state` being known values on every clock edge after reset. The properties count accepted samples and cannot check decoded values, so the decoded values are left to the scoreboard. The stimulus is driven on the falling edge, so it is always settled at the rising edge. It switches `use_min` and `start_state` freely, but the unit looks at them only on the last sample of a block. One phase inserts idle gaps at random points, including block boundaries, to exercise the freeze behaviour.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

    // Number of survivor banks in rotation: write, start-state trace, hold, decode.
    localparam int BANKS  = 4;
    localparam int BANK_W = 2;

    typedef enum logic {
        S_PRIME  = 1'b0,
        S_STREAM = 1'b1
    } phase_e;

endpackage

// File: rtl/vtb_ctrl.sv
module vtb_ctrl
    import vtb_pkg::*;
#(
    parameter int M  = 32,
    localparam int RW = $clog2(M)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [RW-1:0]     row,
    output logic              last_row,
    output logic [BANK_W-1:0] wbank,
    output logic              half,
    output logic              streaming
);

    localparam logic [RW-1:0] ROW_END = RW'(M - 1);

    phase_e          state_q, state_d;
    logic [1:0]      prime_cnt;

    assign last_row = (row == ROW_END);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_PRIME;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_PRIME:  if (adv && last_row && prime_cnt == 2'd3) state_d = S_STREAM;
            S_STREAM: state_d = S_STREAM;
        endcase
    end

    // Outputs
    always_comb begin
        streaming = 1'b0;
        unique case (state_q)
            S_PRIME:  streaming = 1'b0;
            S_STREAM: streaming = 1'b1;
        endcase
    end

    // Block position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row       <= '0;
            wbank     <= '0;
            half      <= 1'b0;
            prime_cnt <= '0;
        end else if (adv) begin
            if (last_row) begin
                row   <= '0;
                wbank <= wbank + 1'b1;
                half  <= ~half;
                if (state_q == S_PRIME) prime_cnt <= prime_cnt + 1'b1;
            end else begin
                row <= row + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vtb_survivor_mem.sv
module vtb_survivor_mem
    import vtb_pkg::*;
#(
    parameter int NS = 16,
    parameter int M  = 32,
    localparam int RW = $clog2(M),
    localparam int SW = $clog2(NS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BANK_W-1:0] w_bank,
    input  logic [RW-1:0]     w_row,
    input  logic [NS-1:0]     w_data,
    input  logic [BANK_W-1:0] a_bank,
    input  logic [RW-1:0]     a_row,
    input  logic [SW-1:0]     a_sel,
    output logic              a_bit,
    input  logic [BANK_W-1:0] b_bank,
    input  logic [RW-1:0]     b_row,
    input  logic [SW-1:0]     b_sel,
    output logic              b_bit
);

    logic [NS-1:0] mem_q [BANKS][M];

    always_ff @(posedge clk) begin
        if (we) mem_q[w_bank][w_row] <= w_data;
    end

    assign a_bit = mem_q[a_bank][a_row][a_sel];
    assign b_bit = mem_q[b_bank][b_row][b_sel];

endmodule

// File: rtl/vtb_reorder_buf.sv
module vtb_reorder_buf #(
    parameter int M  = 32,
    localparam int RW = $clog2(M)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wr_half,
    input  logic [RW-1:0] wr_idx,
    input  logic          wr_bit,
    input  logic [RW-1:0] rd_idx,
    output logic          rd_bit
);

    logic [M-1:0] buf_q [2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int h = 0; h < 2; h++) buf_q[h] <= '0;
        end else if (we) begin
            buf_q[wr_half][wr_idx] <= wr_bit;
        end
    end

    // Read the half filled during the previous block.
    assign rd_bit = buf_q[~wr_half][rd_idx];

endmodule

// File: rtl/vtb_block_traceback.sv
module vtb_block_traceback
    import vtb_pkg::*;
#(
    parameter int K = 5,
    parameter int M = 32,
    localparam int SW = K - 1,
    localparam int NS = 1 << SW,
    localparam int RW = $clog2(M)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [NS-1:0] dec_vec,
    input  logic          use_min,
    input  logic [SW-1:0] start_state,
    output logic          out_valid,
    output logic          out_bit
);

    localparam logic [RW-1:0] ROW_END = RW'(M - 1);

    logic [RW-1:0]     row, rev_row;
    logic              last_row, half, streaming;
    logic [BANK_W-1:0] wbank, tb_bank, dec_bank;
    logic [SW-1:0]     tb_state, dec_state, tb_prev, dec_prev;
    logic              tb_bit, dec_bit;

    vtb_ctrl #(.M(M)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (in_valid),
        .row       (row),
        .last_row  (last_row),
        .wbank     (wbank),
        .half      (half),
        .streaming (streaming)
    );

    assign rev_row  = ROW_END - row;
    assign tb_bank  = wbank - 2'd1;   // block just completed
    assign dec_bank = wbank + 2'd1;   // three blocks back

    vtb_survivor_mem #(.NS(NS), .M(M)) u_mem (
        .clk    (clk),
        .we     (in_valid),
        .w_bank (wbank),
        .w_row  (row),
        .w_data (dec_vec),
        .a_bank (tb_bank),
        .a_row  (rev_row),
        .a_sel  (tb_state),
        .a_bit  (tb_bit),
        .b_bank (dec_bank),
        .b_row  (rev_row),
        .b_sel  (dec_state),
        .b_bit  (dec_bit)
    );

    // Backward step: stored decision becomes the oldest bit.
    assign tb_prev  = {tb_bit,  tb_state[SW-1:1]};
    assign dec_prev = {dec_bit, dec_state[SW-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_state  <= '0;
            dec_state <= '0;
        end else if (in_valid) begin
            if (last_row) begin
                tb_state  <= use_min ? start_state : '0;
                dec_state <= tb_prev;
            end else begin
                tb_state  <= tb_prev;
                dec_state <= dec_prev;
            end
        end
    end

    vtb_reorder_buf #(.M(M)) u_rev (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (in_valid),
        .wr_half (half),
        .wr_idx  (rev_row),
        .wr_bit  (dec_state[0]),
        .rd_idx  (row),
        .rd_bit  (out_bit)
    );

    assign out_valid = in_valid & streaming;

endmodule

// File: rtl/vtb_block_traceback_chk.sv
module vtb_block_traceback_chk #(
    parameter int M = 32
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic out_bit
);

    localparam int FILL = 4 * M;
    localparam int CW   = $clog2(FILL + 1);

    logic [CW-1:0] acc_cnt;
    logic          seen_out;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt  <= '0;
            seen_out <= 1'b0;
        end else begin
            if (in_valid && acc_cnt != CW'(FILL)) acc_cnt <= acc_cnt + 1'b1;
            if (out_valid) seen_out <= 1'b1;
        end
    end

    AST_PRIME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cnt != CW'(FILL)) |-> !out_valid);                          // R1
    AST_STREAM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cnt == CW'(FILL)) |-> (out_valid == in_valid));             // R2
    AST_FIRST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seen_out) |-> (acc_cnt == CW'(FILL)));            // R3
    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !out_valid);                                       // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_bit));                                 // R8

endmodule

bind vtb_block_traceback vtb_block_traceback_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_bit   (out_bit)
);

// File: tb/vtb_block_traceback_tb.sv
module vtb_block_traceback_tb;

    localparam int CLK_P = 10;
    localparam int K     = 5;
    localparam int M     = 32;
    localparam int SW    = K - 1;
    localparam int NS    = 1 << SW;
    localparam int NBLK  = 26;
    localparam int NSMP  = NBLK * M;
    localparam int BLK_A_END = 8;   // consistent path blocks 0..7
    localparam int BLK_B_END = 14;  // state-0 start, blocks 8..13
    localparam int BLK_C_END = 22;  // min-state start with gaps, 14..21

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NS-1:0] dec_vec = '0;
    logic          use_min = 1'b0;
    logic [SW-1:0] start_state = '0;
    logic          out_valid, out_bit;

    int checks = 0;
    int errors = 0;
    int n_in   = 0;
    bit running = 1'b0;

    logic [NS-1:0] dv   [NSMP];
    logic          ubit [NSMP];
    logic [SW-1:0] init_st [NBLK];

    logic       exp_q [$];
    string      req_q [$];

    always #(CLK_P/2) clk = ~clk;

    vtb_block_traceback #(.K(K), .M(M)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .dec_vec     (dec_vec),
        .use_min     (use_min),
        .start_state (start_state),
        .out_valid   (out_valid),
        .out_bit     (out_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (input sample %0d)", req, act, exp, n_in);
        end
    endtask

    // Behavioural block traceback (R4, R5, R6, R7)
    task automatic model_block(input int b, output logic [M-1:0] bits);
        logic [SW-1:0] st;
        st = init_st[b+1];
        for (int r = M - 1; r >= 0; r--)
            st = {dv[(b+1)*M + r][st], st[SW-1:1]};
        for (int r = M - 1; r >= 0; r--) begin
            bits[r] = st[0];
            st = {dv[b*M + r][st], st[SW-1:1]};
        end
    endtask

    task automatic push_expected(input int b);
        logic [M-1:0] bits;
        model_block(b, bits);
        for (int r = 0; r < M; r++) begin
            if (b + 1 < BLK_A_END) begin
                exp_q.push_back(ubit[b*M + r]);
                req_q.push_back("R9");
            end else if (b + 1 < BLK_B_END) begin
                exp_q.push_back(bits[r]);
                req_q.push_back("R5_R7");
            end else begin
                exp_q.push_back(bits[r]);
                req_q.push_back("R6_R7");
            end
        end
    endtask

    task automatic drive_sample(input int t, input logic um, input logic [SW-1:0] ss);
        @(negedge clk);
        in_valid    = 1'b1;
        dec_vec     = dv[t];
        use_min     = um;
        start_state = ss;
    endtask

    task automatic drive_idle();
        @(negedge clk);
        in_valid    = 1'b0;
        dec_vec     = NS'($urandom);
        use_min     = $urandom_range(0, 1) == 1;
        start_state = SW'($urandom);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        #(CLK_P/4);
        if (running) begin
            if (!in_valid) begin
                check(out_valid == 1'b0, "R8 idle out_valid", int'(out_valid), 0);
            end else begin
                if (n_in < 4*M)
                    check(out_valid == 1'b0, "R1 prime", int'(out_valid), 0);
                else
                    check(out_valid == 1'b1, "R2 stream", int'(out_valid), 1);
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3 unexpected output", 1, 0);
                    end else begin
                        logic  e;
                        string rq;
                        e  = exp_q.pop_front();
                        rq = req_q.pop_front();
                        check(out_bit == e, {rq, " R3 R4 bit"}, int'(out_bit), int'(e));
                    end
                end
                n_in++;
            end
        end
    end

    // Separate check of R8 hold of out_bit across an idle cycle
    logic prev_bit;
    bit   prev_idle = 1'b0;
    always @(negedge clk) begin
        #(CLK_P/4 + 1);
        if (running) begin
            if (prev_idle)
                check(out_bit == prev_bit, "R8 hold out_bit", int'(out_bit), int'(prev_bit));
            prev_idle = !in_valid;
            prev_bit  = out_bit;
        end
    end

    initial begin
        logic [SW-1:0] s, olds;
        logic [SW-1:0] ss;
        logic          um;
        int            t;

        // Build stimulus
        s = '0;
        for (int i = 0; i < NSMP; i++) begin
            dv[i]   = NS'($urandom);
            ubit[i] = $urandom_range(0, 1) == 1;
            if (i < BLK_A_END * M) begin
                olds = s;
                s = {olds[SW-2:0], ubit[i]};
                dv[i][s] = olds[SW-1];
            end
        end

        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        s = '0;
        for (int b = 0; b < NBLK; b++) begin
            for (int r = 0; r < M; r++) begin
                t = b*M + r;
                if (b < BLK_A_END) begin
                    s  = {s[SW-2:0], ubit[t]};
                    um = 1'b1;
                    ss = s;
                end else if (b < BLK_B_END) begin
                    um = 1'b0;
                    ss = SW'($urandom);
                end else if (b < BLK_C_END) begin
                    um = (r == M - 1) ? 1'b1 : ($urandom_range(0, 1) == 1);
                    ss = SW'($urandom);
                    if ($urandom_range(0, 3) == 0) drive_idle();
                    if (r == 0 && $urandom_range(0, 1) == 1) drive_idle();
                end else begin
                    um = 1'b0;
                    ss = SW'($urandom);
                end
                if (r == M - 1) init_st[b] = um ? ss : '0;
                drive_sample(t, um, ss);
            end
            if (b >= 1 && b - 1 <= NBLK - 5) push_expected(b - 1);
        end
        drive_idle();
        drive_idle();
        @(negedge clk);
        #(CLK_P/2);
        check(exp_q.size() == 0, "R3 all bits released", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule